// File: doc/BRIEF.md
# Delta-Sigma ADC Command and Register Sequencer

This block is the host-side SPI master for a multichannel delta-sigma converter. It sends the converter's one-byte opcodes and carries out single-register reads and writes. A host asks for an operation through a simple request port. The block returns a done pulse, plus the register value when the operation is a read. An address or operation it cannot serve is refused at once with an error pulse.

After reset the block brings the converter up without help from the host:

- It pulses the converter's reset pin low and waits for the converter to settle.
- It leaves continuous-read mode.
- It reads the identification register at address 0 and decodes the device family and channel count.

Host requests are accepted only after bring-up has finished.

All converter timing is counted in system clocks per modulator clock (`MCLK_DIV`). This covers the reset pulse, the settle wait, the chip-select guard and the SCLK rate limit. The SCLK half period is `SCLK_HALF` system clocks, and `2*SCLK_HALF` must be at least `MCLK_DIV`.

Top module: `adc_cmd_engine`

## Requirements
- R1: After `rst_ni` is released, `adc_rst_no` stays low for at least 2 modulator clocks, that is at least `2*MCLK_DIV` system cycles. After it rises, chip select stays high for at least 18 modulator clocks.
- R2: Bring-up sends two frames before anything else. The first is the single byte 0x11. The second is the three bytes 0x20, 0x00, 0x00. After the second frame, `init_done_o` rises and `busy_o` falls.
- R3: The identification byte is decoded as follows:
  - Bits [7:3] equal to 5'b10010 give a standard part, with `family_ext_o`=0.
  - Bits [7:3] equal to 5'b11010 give an extended part, with `family_ext_o`=1.
  - Any other value of bits [7:3] sets `id_fail_o`.
  - `chan_count_o` = 4 + 2*bits[2:0].
- R4: Operation codes 0 to 7 each send one byte in their own chip-select frame. The bytes are, in code order: 0x02, 0x04, 0x06, 0x08, 0x0A, 0x10, 0x11, 0x12.
- R5: Operation code 9 (register write) sends three bytes in one frame: (0x40 | address), then 0x00, then the write data.
- R6: Operation code 8 (register read) sends three bytes: (0x20 | address), then 0x00, then 0x00. `rdata_o` is loaded with the MISO byte received during the third byte.
- R7: The SPI timing is as follows:
  - SCLK idles low and toggles only while chip select is low.
  - MOSI changes only at SCLK rising edges, and MISO is sampled at falling edges.
  - Bytes are sent most significant bit first.
  - Consecutive SCLK rising edges are at least `MCLK_DIV` system cycles apart.
- R8: Chip select stays low for at least 4 modulator clocks after the last SCLK falling edge of a frame.
- R9: After the reset opcode (operation 2), `done_o` comes no earlier than 18 modulator clocks after chip select rises.
- R10: A request is accepted only while `busy_o` is low. `busy_o` stays high from acceptance until the cycle in which `done_o` pulses. Requests presented while busy are ignored and cause no error and no frame.
- R11: Two kinds of request are rejected: a read or write whose address is above 0x19, and any operation code above 9. A rejected request gives a one-cycle `err_o` pulse in the next cycle, with no frame, no busy and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 4 | Operation code (0-9) |
| req_addr_i | input | 8 | Register address |
| req_wdata_i | input | 8 | Register write data |
| busy_o | output | 1 | Engine busy (bring-up or request) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| rdata_o | output | 8 | Last register read value |
| init_done_o | output | 1 | Bring-up finished |
| id_fail_o | output | 1 | Unknown device family |
| family_ext_o | output | 1 | Extended family detected |
| chan_count_o | output | 5 | Decoded channel count |
| adc_rst_no | output | 1 | Converter reset pin, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to converter |
| cs_no | output | 1 | SPI chip select, active low |
| miso_i | input | 1 | SPI data from converter |

## Verification
A bench slave decodes every frame and replies with a register image. This exposes a design that drives the wrong opcode or misplaces the address, or one that samples MISO on the wrong edge, which would give shifted read data. Timing is measured at the pins: SCLK spacing, the guard from the last falling edge to chip-select release, the reset pulse width, and the settle waits after bring-up and after the reset opcode. A design that releases chip select early or finishes a reset too soon is therefore caught. Identification bytes from the standard family, the extended family and an unknown family check the decode. Requests made while busy, addresses one past the limit and undefined operation codes check that nothing reaches the bus.

// File: rtl/adc_eng_pkg.sv
`timescale 1ns/1ps
package adc_eng_pkg;
  typedef enum logic [3:0] {
    OP_WAKE = 4'd0, OP_STBY = 4'd1, OP_RESET = 4'd2, OP_START = 4'd3,
    OP_STOP = 4'd4, OP_CONT_ON = 4'd5, OP_CONT_OFF = 4'd6, OP_READ_DATA = 4'd7,
    OP_REG_RD = 4'd8, OP_REG_WR = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_PULSE, ST_SETTLE, ST_IDLE, ST_START, ST_SHIFT, ST_GUARD, ST_RWAIT, ST_FINISH
  } st_e;

  localparam logic [7:0] OPC_CONT_OFF = 8'h11;
  localparam logic [7:0] OPC_REG_RD   = 8'h20;
  localparam logic [7:0] OPC_REG_WR   = 8'h40;
  localparam logic [4:0] FAM_STD      = 5'b10010;
  localparam logic [4:0] FAM_EXT      = 5'b11010;

  function automatic logic [7:0] op_code(input logic [3:0] op);
    case (op)
      OP_WAKE:      return 8'h02;
      OP_STBY:      return 8'h04;
      OP_RESET:     return 8'h06;
      OP_START:     return 8'h08;
      OP_STOP:      return 8'h0A;
      OP_CONT_ON:   return 8'h10;
      OP_CONT_OFF:  return OPC_CONT_OFF;
      OP_READ_DATA: return 8'h12;
      OP_REG_RD:    return OPC_REG_RD;
      OP_REG_WR:    return OPC_REG_WR;
      default:      return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/adc_eng_timer.sv
`timescale 1ns/1ps
module adc_eng_timer #(
  parameter int unsigned W    = 8,
  parameter int unsigned INIT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         exp_q;

  // counts val_i cycles after load, then pulses expire_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= W'(INIT);
      run_q <= (INIT != 0);
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= val_i;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q <= W'(1)) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end

  assign expire_o = exp_q;

  p_no_expire_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !$past(expire_o));
endmodule

// File: rtl/adc_eng_shift.sv
`timescale 1ns/1ps
module adc_eng_shift #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic             act_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       half_q;
  logic [7:0]       tx_sh, rx_sh, rx_q;
  logic             sclk_q, mosi_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; div_q <= '0; half_q <= '0;
      tx_sh <= '0; rx_sh <= '0; rx_q <= '0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        div_q  <= '0;
        half_q <= '0;
        tx_sh  <= tx_i;
      end else if (act_q) begin
        if (div_q == DIV_W'(HALF - 1)) begin
          div_q  <= '0;
          half_q <= half_q + 4'd1;
          if (!half_q[0]) begin
            // leading edge: present next bit
            sclk_q <= 1'b1;
            mosi_q <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end else begin
            // trailing edge: capture
            sclk_q <= 1'b0;
            rx_sh  <= {rx_sh[6:0], miso_i};
            if (half_q == 4'd15) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
              rx_q   <= {rx_sh[6:0], miso_i};
            end
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  p_mosi_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_done_sclk_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);
endmodule

// File: rtl/adc_cmd_engine.sv
`timescale 1ns/1ps
module adc_cmd_engine
  import adc_eng_pkg::*;
#(
  parameter int unsigned SCLK_HALF   = 2,
  parameter int unsigned MCLK_DIV    = 4,
  parameter int unsigned GUARD_MCLK  = 4,
  parameter int unsigned SETTLE_MCLK = 18,
  parameter int unsigned PULSE_MCLK  = 2,
  parameter logic [7:0]  MAX_ADDR    = 8'h19
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [3:0] req_op_i,
  input  logic [7:0] req_addr_i,
  input  logic [7:0] req_wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o,
  output logic       init_done_o,
  output logic       id_fail_o,
  output logic       family_ext_o,
  output logic [4:0] chan_count_o,
  output logic       adc_rst_no,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       cs_no,
  input  logic       miso_i
);
  localparam int unsigned GUARD_CYC  = GUARD_MCLK * MCLK_DIV;
  localparam int unsigned SETTLE_CYC = SETTLE_MCLK * MCLK_DIV;
  localparam int unsigned PULSE_CYC  = PULSE_MCLK * MCLK_DIV;
  localparam int unsigned TMR_MAX    = (GUARD_CYC > SETTLE_CYC)
                                     ? ((GUARD_CYC > PULSE_CYC) ? GUARD_CYC : PULSE_CYC)
                                     : ((SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC);
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);

  st_e        state;
  logic       cs_q, arst_q, in_boot, boot_id;
  logic [1:0] byte_idx, last_idx;
  logic [7:0] cmd_q, wdat_q, rdata_q;
  logic       is_read, is_rst;
  logic       done_q, err_q, init_q, id_fail_q, fam_ext_q;
  logic [4:0] chan_q;

  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             bx_start, bx_done;
  logic [7:0]       bx_tx, bx_rx;

  logic is_reg_op, req_ok;
  assign is_reg_op = (req_op_i == OP_REG_RD) || (req_op_i == OP_REG_WR);
  assign req_ok    = (req_op_i <= OP_REG_WR) && (!is_reg_op || (req_addr_i <= MAX_ADDR));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(GUARD_CYC);
    if (state == ST_PULSE && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(SETTLE_CYC);
    end else if (state == ST_SHIFT && bx_done && byte_idx == last_idx) begin
      tmr_load = 1'b1;
    end else if (state == ST_GUARD && tmr_exp && is_rst) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(SETTLE_CYC);
    end
  end

  assign bx_start = (state == ST_START);
  assign bx_tx    = (byte_idx == 2'd0) ? cmd_q : (byte_idx == 2'd1) ? 8'h00 : wdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_PULSE; cs_q <= 1'b1; arst_q <= 1'b0;
      in_boot <= 1'b1; boot_id <= 1'b0;
      byte_idx <= '0; last_idx <= '0; cmd_q <= '0; wdat_q <= '0; rdata_q <= '0;
      is_read <= 1'b0; is_rst <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; init_q <= 1'b0;
      id_fail_q <= 1'b0; fam_ext_q <= 1'b0; chan_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_PULSE: if (tmr_exp) begin
          arst_q <= 1'b1;
          state  <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) begin
          cmd_q <= OPC_CONT_OFF; last_idx <= 2'd0; byte_idx <= 2'd0;
          is_read <= 1'b0; is_rst <= 1'b0;
          state <= ST_START;
        end
        ST_IDLE: if (req_valid_i) begin
          if (!req_ok) begin
            err_q <= 1'b1;
          end else begin
            cmd_q    <= op_code(req_op_i) | (is_reg_op ? req_addr_i : 8'h00);
            wdat_q   <= (req_op_i == OP_REG_WR) ? req_wdata_i : 8'h00;
            last_idx <= is_reg_op ? 2'd2 : 2'd0;
            byte_idx <= 2'd0;
            is_read  <= (req_op_i == OP_REG_RD);
            is_rst   <= (req_op_i == OP_RESET);
            state    <= ST_START;
          end
        end
        ST_START: begin
          cs_q  <= 1'b0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (bx_done) begin
          if (byte_idx == last_idx) begin
            if (is_read) rdata_q <= bx_rx;
            state <= ST_GUARD;
          end else begin
            byte_idx <= byte_idx + 2'd1;
            state    <= ST_START;
          end
        end
        ST_GUARD: if (tmr_exp) begin
          cs_q  <= 1'b1;
          state <= is_rst ? ST_RWAIT : ST_FINISH;
        end
        ST_RWAIT: if (tmr_exp) state <= ST_FINISH;
        ST_FINISH: begin
          if (in_boot) begin
            if (!boot_id) begin
              boot_id <= 1'b1;
              cmd_q <= OPC_REG_RD; wdat_q <= 8'h00;
              last_idx <= 2'd2; byte_idx <= 2'd0;
              is_read <= 1'b1; is_rst <= 1'b0;
              state <= ST_START;
            end else begin
              in_boot   <= 1'b0;
              init_q    <= 1'b1;
              fam_ext_q <= (rdata_q[7:3] == FAM_EXT);
              id_fail_q <= (rdata_q[7:3] != FAM_STD) && (rdata_q[7:3] != FAM_EXT);
              chan_q    <= 5'd4 + {1'b0, rdata_q[2:0], 1'b0};
              state     <= ST_IDLE;
            end
          end else begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  adc_eng_timer #(.W(TMR_W), .INIT(PULSE_CYC)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .expire_o(tmr_exp)
  );

  adc_eng_shift #(.HALF(SCLK_HALF)) i_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(bx_start), .tx_i(bx_tx), .miso_i(miso_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(bx_done), .rx_o(bx_rx)
  );

  assign busy_o       = (state != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign rdata_o      = rdata_q;
  assign init_done_o  = init_q;
  assign id_fail_o    = id_fail_q;
  assign family_ext_o = fam_ext_q;
  assign chan_count_o = chan_q;
  assign adc_rst_no   = arst_q;
  assign cs_no        = cs_q;

  p_sclk_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  p_frame_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  p_reject_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !req_ok) |=> (err_o && !busy_o && cs_no));
  p_rst_pin_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rst_no |-> (cs_no && !init_done_o));
  p_init_before_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> init_done_o);
endmodule

// File: tb/test_adc_cmd_engine.sv
`timescale 1ns/1ps
module test_adc_cmd_engine;
  localparam int SCLK_HALF = 2;
  localparam int MCLK_DIV  = 4;
  localparam int GUARD_C   = 4 * MCLK_DIV;
  localparam int SETTLE_C  = 18 * MCLK_DIV;
  localparam int PULSE_C   = 2 * MCLK_DIV;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic busy, done, err, init_done, id_fail, fam_ext, adc_rst_n, sclk, mosi, cs_n;
  logic [7:0] rdata;
  logic [4:0] chan_cnt;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  adc_cmd_engine #(.SCLK_HALF(SCLK_HALF), .MCLK_DIV(MCLK_DIV)) i_adc_cmd_engine (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
    .err_o(err), .rdata_o(rdata), .init_done_o(init_done), .id_fail_o(id_fail),
    .family_ext_o(fam_ext), .chan_count_o(chan_cnt), .adc_rst_no(adc_rst_n),
    .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n), .miso_i(miso)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] id_val = 8'h92;

  // slave model and pin monitor, polled away from the active edge
  int cyc = 0, nf = 0, bitc = 0, nb = 0;
  int last_rise = -1, last_fall = 0, sclk_bad = 0, mosi_bad = 0;
  int rst_fall_cyc = 0, rst_rel_cyc = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_arst = 1'b1, mosi_rise = 1'b0;
  logic [7:0] srx = '0, stx = '0;
  logic [7:0] fb [0:2];
  logic [7:0] sregs [0:31];
  logic [7:0] logb [0:15][0:2];
  int logn [0:15], logguard [0:15], logrise [0:15], logfall [0:15];
  int cur_fall = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_ni) for (int i = 0; i < 32; i++) sregs[i] = 8'h00;
    if (prev_arst && !adc_rst_n) rst_fall_cyc = cyc;
    if (!prev_arst && adc_rst_n) rst_rel_cyc = cyc;
    if (prev_cs && !cs_n) begin
      bitc = 0; nb = 0; last_rise = -1; cur_fall = cyc;
    end
    if (!prev_sclk && sclk) begin
      if (cs_n) sclk_bad++;
      if (last_rise >= 0 && cyc - last_rise < MCLK_DIV) sclk_bad++;
      last_rise = cyc;
      if (bitc % 8 == 0) begin
        if (nb == 2 && fb[0][7:5] == 3'b001)
          stx = (fb[0][4:0] == 5'd0) ? id_val : sregs[fb[0][4:0]];
        else
          stx = 8'hA5;
      end
      miso = stx[7];
      stx = {stx[6:0], 1'b0};
      mosi_rise = mosi;
    end
    if (prev_sclk && !sclk) begin
      if (mosi != mosi_rise) mosi_bad++;
      srx = {srx[6:0], mosi};
      bitc++;
      last_fall = cyc;
      if (bitc % 8 == 0 && nb < 3) begin
        fb[nb] = srx;
        nb++;
      end
    end
    if (!prev_cs && cs_n) begin
      logn[nf % 16] = nb;
      for (int i = 0; i < 3; i++) logb[nf % 16][i] = (i < nb) ? fb[i] : 8'h00;
      logguard[nf % 16] = cyc - last_fall;
      logrise[nf % 16] = cyc;
      logfall[nf % 16] = cur_fall;
      if (nb == 3 && fb[0][7:5] == 3'b010) sregs[fb[0][4:0]] = fb[2];
      nf++;
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_arst = adc_rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  function automatic logic [7:0] exp_byte0(input int op, input logic [7:0] a);
    case (op)
      0: return 8'h02; 1: return 8'h04; 2: return 8'h06; 3: return 8'h08;
      4: return 8'h0A; 5: return 8'h10; 6: return 8'h11; 7: return 8'h12;
      8: return 8'h20 | a;
      default: return 8'h40 | a;
    endcase
  endfunction

  logic [7:0] exp_regs [0:31];

  task automatic boot(input logic [7:0] id);
    int base, t;
    id_val = id;
    base = nf;
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < 32; i++) exp_regs[i] = 8'h00;
    chk(busy == 1'b1 && adc_rst_n == 1'b0, "R1 reset state", {busy, adc_rst_n}, 2);
    t = 0;
    while (!init_done && t < 5000) begin @(negedge clk); t++; end
    chk(init_done == 1'b1 && busy == 1'b0, "R2 init done", {init_done, busy}, 2);
    chk(rst_rel_cyc - rst_fall_cyc >= PULSE_C, "R1 pulse width", rst_rel_cyc - rst_fall_cyc, PULSE_C);
    chk(logfall[base % 16] - rst_rel_cyc >= SETTLE_C, "R1 settle", logfall[base % 16] - rst_rel_cyc, SETTLE_C);
    chk(nf == base + 2, "R2 frame count", nf - base, 2);
    chk(logn[base % 16] == 1 && logb[base % 16][0] == 8'h11, "R2 exit continuous", logb[base % 16][0], 8'h11);
    chk(logn[(base + 1) % 16] == 3 && logb[(base + 1) % 16][0] == 8'h20 &&
        logb[(base + 1) % 16][1] == 8'h00 && logb[(base + 1) % 16][2] == 8'h00,
        "R2 id read", logb[(base + 1) % 16][0], 8'h20);
    chk(id_fail == !(id[7:3] == 5'b10010 || id[7:3] == 5'b11010), "R3 id_fail", id_fail, 0);
    chk(fam_ext == (id[7:3] == 5'b11010), "R3 family_ext", fam_ext, id[7:3] == 5'b11010);
    chk(chan_cnt == 5'd4 + 5'(2 * id[2:0]), "R3 channels", chan_cnt, 4 + 2 * id[2:0]);
  endtask

  task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] d, input bit poke);
    int base, t, k, saw_err;
    logic [7:0] e2;
    base = nf;
    saw_err = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke) begin
      req_valid = 1'b1; req_op = 4'd8; req_addr = 8'h1F;
      @(negedge clk);
      req_valid = 1'b0;
      if (err) saw_err++;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk); t++;
      if (err) saw_err++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R10 done ends busy", {done, busy}, 2);
    chk(saw_err == 0 && nf == base + 1, "R10 single frame, no error", nf - base, 1);
    k = base % 16;
    e2 = (op == 9) ? d : 8'h00;
    if (op >= 8) begin
      chk(logn[k] == 3 && logb[k][0] == exp_byte0(op, a) && logb[k][1] == 8'h00 && logb[k][2] == e2,
          (op == 9) ? "R5 write frame" : "R6 read frame", {logb[k][0], logb[k][2]}, {exp_byte0(op, a), e2});
    end else begin
      chk(logn[k] == 1 && logb[k][0] == exp_byte0(op, a), "R4 opcode frame", logb[k][0], exp_byte0(op, a));
    end
    chk(logguard[k] >= GUARD_C, "R8 cs guard", logguard[k], GUARD_C);
    if (op == 8) begin
      // address 0 always answers with the identification byte
      e2 = (a == 8'h00) ? id_val : exp_regs[a[4:0]];
      chk(rdata == e2, "R6 read data", rdata, e2);
    end
    if (op == 9 && a != 8'h00) exp_regs[a[4:0]] = d;
    if (op == 2) chk(cyc - logrise[k] >= SETTLE_C, "R9 reset settle", cyc - logrise[k], SETTLE_C);
  endtask

  task automatic do_bad(input int op, input logic [7:0] a);
    int base, saw_done;
    base = nf;
    saw_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R11 error pulse", {err, busy}, 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done || err) saw_done++;
    end
    chk(nf == base && saw_done == 0, "R11 no activity", nf - base, 0);
  endtask

  initial begin
    int s, op;
    logic [7:0] a;
    s = $urandom(32'h5EED);
    boot(8'h92);
    // directed corners
    do_op(9, 8'h19, 8'h3C, 1'b0);
    do_op(8, 8'h19, 8'h00, 1'b0);
    do_op(8, 8'h00, 8'h00, 1'b1);
    do_op(2, 8'h00, 8'h00, 1'b0);
    do_bad(8, 8'h1A);
    do_bad(9, 8'hFF);
    do_bad(10, 8'h00);
    do_bad(15, 8'h05);
    for (int it = 0; it < 60; it++) begin
      op = int'($urandom % 10);
      a = 8'($urandom % 26);
      do_op(op, a, 8'($urandom), 1'($urandom % 4 == 0));
    end
    chk(sclk_bad == 0, "R7 sclk spacing", sclk_bad, 0);
    chk(mosi_bad == 0, "R7 mosi edge", mosi_bad, 0);
    boot(8'hD5);
    do_op(8, 8'h00, 8'h00, 1'b0);
    boot(8'h55);
    do_op(0, 8'h00, 8'h00, 1'b0);
    summary();
  end
endmodule